// File: doc/BRIEF.md
# Three-Phase Bridge Shoot-Through Interlock

This block is the command logic in front of the gate drivers of a three-phase half-bridge. Each phase has two command inputs. One command asks for the low-side switch and is active high. The other asks for the high-side switch and is active low. The block produces one gate-enable output for the high side and one for the low side of every phase. It ensures that the two switches of a phase never conduct together, and it inserts a programmable dead interval, counted in clock cycles, before any switch of a phase is turned on.

The two sides are not treated equally. A low-side request always wins. It can preempt a conducting high side, which is switched off at once. The low side follows only after the dead interval. A high-side request is held off for as long as the low side is wanted, and it still has to wait out the full dead interval. All three phases are identical instances of the same state machine. They share one active-low enable and one dead-time setting. Every command input, including the enable, passes through a two-flop synchronizer before it reaches the state machines.

Each phase state machine has four states: `ST_OFF` (both gates off, idle), `ST_DEAD` (both gates off, a turn-on pending for a recorded side, with a down-counter timing the interval), `ST_HIGH_ON` and `ST_LOW_ON`. The transitions are as follows.
- Deassertion of the enable sends every state to `ST_OFF`.
- From `ST_OFF`, a low request or a high request enters `ST_DEAD`, with low taking precedence.
- From `ST_HIGH_ON`, a low request enters `ST_DEAD` with low pending. Losing the high request returns to `ST_OFF`.
- From `ST_LOW_ON`, losing the low request returns to `ST_OFF`.
- In `ST_DEAD` with low pending, losing the request cancels to `ST_OFF`. Otherwise the expired counter moves to `ST_LOW_ON`.
- In `ST_DEAD` with high pending, a low request switches the pending side to low and restarts the counter. Losing the high request cancels to `ST_OFF`. Otherwise the expired counter moves to `ST_HIGH_ON`.

Top module: `bridge_interlock`

## Requirements
- R1: During reset, and afterwards until a request has passed through the interlock, every gate output is 0.
- R2: Let D be the dead-time input, with the value 0 treated as 1. A low-side request held from an idle, enabled phase raises that phase's low gate just after the (D+3)-th rising clock edge, counting from the edge at which the request is first sampled: two synchronizer stages, one edge to enter the dead interval, then D dead cycles.
- R3: A low-side input at 1 requests the low switch. A high-side input at 0 requests the high switch. A gate only rises if its own request was present three edges earlier.
- R4: In no cycle are the high and low gate outputs of the same phase both 1.
- R5: When both requests of a phase are present, the low side is the one turned on. A high gate never rises while the low request is present.
- R6: When a low request reaches a phase whose high gate is on, the high gate drops on the very edge at which the request is acted on. The low gate then rises after D cycles with both gates off.
- R7: While the low gate is on, a high request has no effect. After the low request is withdrawn, the high gate rises only after at least D further cycles with both gates off.
- R8: Every rise of a gate is preceded by at least D consecutive cycles in which both gates of that phase are off.
- R9: An enable input of 1 forces every gate off two edges after it is sampled and returns every phase to idle. After re-enabling, a request again passes through the full dead interval before any gate rises.
- R10: A request withdrawn before its dead interval completes is cancelled, and neither gate of that phase turns on.
- R11: The three phases operate independently under a shared enable and dead-time setting. Traffic on one phase never alters the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_cmd | input | N_PHASE | Per-phase low-side request, active high |
| hi_cmd_n | input | N_PHASE | Per-phase high-side request, active low |
| enable_n | input | 1 | Shared enable, 0 permits switching |
| dead_cycles | input | DT_W | Dead interval in clock cycles (0 acts as 1) |
| hi_gate | output | N_PHASE | Per-phase high-side gate enable |
| lo_gate | output | N_PHASE | Per-phase low-side gate enable |

## Verification
The dead-gap property compares the count of off cycles against the current value of `dead_cycles`. It therefore assumes that the setting changes only while the enable is deasserted and every gate is off. The other timing properties look exactly three edges back, which assumes the fixed two-flop synchronizer on every command. The stimulus follows these assumptions: it changes the dead time only inside a disabled window, after the gates have settled off. It then drives directed handovers per requirement and a long pseudo-random phase with the setting held constant. Enable toggles are allowed in that phase because they only ever force the gates off.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // Per-phase interlock states
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_HIGH_ON = 2'd1,
        ST_LOW_ON  = 2'd2,
        ST_DEAD    = 2'd3
    } leg_state_t;

    // Side whose turn-on is pending during a dead interval
    typedef enum logic {
        SIDE_HIGH = 1'b0,
        SIDE_LOW  = 1'b1
    } side_t;

    // Decoded, synchronized request pair of one phase (both active high)
    typedef struct packed {
        logic lo_req;
        logic hi_req;
    } leg_req_t;

endpackage

// File: rtl/cmd_sync.sv
// Two-flop synchronizer for a vector of command bits, with a per-bit
// reset value so that every command resets to its inactive level.
module cmd_sync #(
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/dead_timer.sv
// Down-counter timing one dead interval. A load of L (L >= 1) makes
// expired true after L-1 further edges, so an interval entered together
// with the load lasts exactly L cycles.
module dead_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val - 1'b1;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);

endmodule

// File: rtl/phase_interlock.sv
// One phase of the shoot-through interlock (R4..R10).
module phase_interlock
    import bridge_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,    // synchronized, active high
    input  leg_req_t      req,       // synchronized, active high
    input  logic [CW-1:0] dead_len,  // already clamped to >= 1
    output logic          hi_gate,
    output logic          lo_gate
);

    leg_state_t state, state_nxt;
    side_t      pend,  pend_nxt;
    logic       tmr_load;
    logic       tmr_expired;

    dead_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dead_len),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            pend  <= SIDE_LOW;
        end else begin
            state <= state_nxt;
            pend  <= pend_nxt;
        end
    end

    // Next-state logic: low side wins everywhere (R5), disable wins over all (R9)
    always_comb begin
        state_nxt = state;
        pend_nxt  = pend;
        tmr_load  = 1'b0;
        if (!enable) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (req.lo_req) begin
                        state_nxt = ST_DEAD;
                        pend_nxt  = SIDE_LOW;
                        tmr_load  = 1'b1;
                    end else if (req.hi_req) begin
                        state_nxt = ST_DEAD;
                        pend_nxt  = SIDE_HIGH;
                        tmr_load  = 1'b1;
                    end
                end
                ST_HIGH_ON: begin
                    // R6: preempt the conducting high side
                    if (req.lo_req) begin
                        state_nxt = ST_DEAD;
                        pend_nxt  = SIDE_LOW;
                        tmr_load  = 1'b1;
                    end else if (!req.hi_req) begin
                        state_nxt = ST_OFF;
                    end
                end
                ST_LOW_ON: begin
                    // R7: high request ignored while low is held
                    if (!req.lo_req) begin
                        state_nxt = ST_OFF;
                    end
                end
                ST_DEAD: begin
                    if (pend == SIDE_LOW) begin
                        if (!req.lo_req) begin
                            state_nxt = ST_OFF;          // R10 cancel
                        end else if (tmr_expired) begin
                            state_nxt = ST_LOW_ON;
                        end
                    end else begin
                        if (req.lo_req) begin
                            pend_nxt  = SIDE_LOW;        // R5 retarget
                            tmr_load  = 1'b1;
                        end else if (!req.hi_req) begin
                            state_nxt = ST_OFF;          // R10 cancel
                        end else if (tmr_expired) begin
                            state_nxt = ST_HIGH_ON;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        hi_gate = 1'b0;
        lo_gate = 1'b0;
        unique case (state)
            ST_HIGH_ON: hi_gate = 1'b1;
            ST_LOW_ON:  lo_gate = 1'b1;
            ST_OFF,
            ST_DEAD:    ;
        endcase
    end

endmodule

// File: rtl/bridge_interlock.sv
// Three-phase shoot-through interlock top (R1..R11).
module bridge_interlock
    import bridge_pkg::*;
#(
    parameter int N_PHASE = 3,
    parameter int DT_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] lo_cmd,
    input  logic [N_PHASE-1:0] hi_cmd_n,
    input  logic               enable_n,
    input  logic [DT_W-1:0]    dead_cycles,
    output logic [N_PHASE-1:0] hi_gate,
    output logic [N_PHASE-1:0] lo_gate
);

    localparam int SYNC_W = 2 * N_PHASE + 1;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {N_PHASE{1'b1}}, {N_PHASE{1'b0}}};

    logic [SYNC_W-1:0]  sync_q;
    logic [N_PHASE-1:0] lo_s;
    logic [N_PHASE-1:0] hi_n_s;
    logic               en_n_s;
    logic [DT_W-1:0]    dead_eff;

    // R1/R3: commands synchronized, resetting to their inactive levels
    cmd_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({enable_n, hi_cmd_n, lo_cmd}),
        .q_sync  (sync_q)
    );

    assign lo_s   = sync_q[N_PHASE-1:0];
    assign hi_n_s = sync_q[2*N_PHASE-1:N_PHASE];
    assign en_n_s = sync_q[SYNC_W-1];

    // R8: a zero setting acts as one cycle; the value is taken when an interval starts
    assign dead_eff = (dead_cycles == '0) ? DT_W'(1) : dead_cycles;

    // R11: identical independent phases
    for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
        leg_req_t leg_req;
        assign leg_req.lo_req = lo_s[p];
        assign leg_req.hi_req = ~hi_n_s[p];

        phase_interlock #(.CW(DT_W)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (~en_n_s),
            .req      (leg_req),
            .dead_len (dead_eff),
            .hi_gate  (hi_gate[p]),
            .lo_gate  (lo_gate[p])
        );
    end

endmodule

// File: rtl/bridge_interlock_chk.sv
// Property checker bound to the interlock top.
module bridge_interlock_chk #(
    parameter int N_PHASE = 3,
    parameter int DT_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PHASE-1:0] lo_cmd,
    input logic [N_PHASE-1:0] hi_cmd_n,
    input logic               enable_n,
    input logic [DT_W-1:0]    dead_cycles,
    input logic [N_PHASE-1:0] hi_gate,
    input logic [N_PHASE-1:0] lo_gate
);

    int dead_min;
    assign dead_min = (dead_cycles == '0) ? 1 : int'(dead_cycles);

    for (genvar g = 0; g < N_PHASE; g++) begin : g_chk
        logic [15:0] off_run;

        // Consecutive cycles with both gates of this phase off (saturating)
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_run <= '0;
            end else if (hi_gate[g] || lo_gate[g]) begin
                off_run <= '0;
            end else if (off_run != 16'hFFFF) begin
                off_run <= off_run + 16'd1;
            end
        end

        assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi_gate[g] && lo_gate[g]));

        assert_dead_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(hi_gate[g]) || $rose(lo_gate[g])) |-> (int'(off_run) >= dead_min));

        assert_lo_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo_gate[g]) |-> $past(lo_cmd[g], 3));

        assert_hi_yield_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hi_gate[g]) |-> (!$past(hi_cmd_n[g], 3) && !$past(lo_cmd[g], 3)));

        assert_enabled_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(hi_gate[g]) || $rose(lo_gate[g])) |-> !$past(enable_n, 3));
    end

    assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable_n, 2) |=> (hi_gate == '0 && lo_gate == '0));

endmodule

bind bridge_interlock bridge_interlock_chk #(
    .N_PHASE (N_PHASE),
    .DT_W    (DT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_cmd      (lo_cmd),
    .hi_cmd_n    (hi_cmd_n),
    .enable_n    (enable_n),
    .dead_cycles (dead_cycles),
    .hi_gate     (hi_gate),
    .lo_gate     (lo_gate)
);

// File: tb/bridge_interlock_tb.sv
module bridge_interlock_tb;

    localparam int NP = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] lo_cmd = '0;
    logic [NP-1:0] hi_cmd_n = '1;
    logic          enable_n = 1'b1;
    logic [DW-1:0] dead_cycles = 8'd4;
    logic [NP-1:0] hi_gate;
    logic [NP-1:0] lo_gate;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bridge_interlock #(.N_PHASE(NP), .DT_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lo_cmd(lo_cmd), .hi_cmd_n(hi_cmd_n),
        .enable_n(enable_n), .dead_cycles(dead_cycles),
        .hi_gate(hi_gate), .lo_gate(lo_gate)
    );

    // ---------------- behavioural reference model ----------------
    // mode: 0 idle, 1 high conducting, 2 low conducting, 3 waiting
    int m_mode[NP];
    int m_want_low[NP];
    int m_left[NP];
    bit q_lo[$], q_hin[$], q_en[$];   // per-edge history of sampled inputs
    bit d1_lo[NP], d2_lo[NP], d1_hin[NP], d2_hin[NP];
    bit d1_en, d2_en;

    initial begin
        for (int i = 0; i < NP; i++) begin
            m_mode[i] = 0; m_want_low[i] = 1; m_left[i] = 0;
            d1_lo[i] = 0; d2_lo[i] = 0; d1_hin[i] = 1; d2_hin[i] = 1;
        end
        d1_en = 1; d2_en = 1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_mode[i] = 0; m_want_low[i] = 1; m_left[i] = 0;
                d1_lo[i] = 0; d2_lo[i] = 0; d1_hin[i] = 1; d2_hin[i] = 1;
            end
            d1_en = 1; d2_en = 1;
        end else begin
            int d;
            d = (dead_cycles == 0) ? 1 : int'(dead_cycles);
            for (int i = 0; i < NP; i++) begin
                bit lo_r, hi_r, start;
                lo_r  = d2_lo[i];
                hi_r  = !d2_hin[i];
                start = 0;
                if (d2_en) begin
                    m_mode[i] = 0;
                end else if (m_mode[i] == 0) begin
                    if (lo_r)      begin m_mode[i] = 3; m_want_low[i] = 1; start = 1; end
                    else if (hi_r) begin m_mode[i] = 3; m_want_low[i] = 0; start = 1; end
                end else if (m_mode[i] == 1) begin
                    if (lo_r)       begin m_mode[i] = 3; m_want_low[i] = 1; start = 1; end
                    else if (!hi_r) m_mode[i] = 0;
                end else if (m_mode[i] == 2) begin
                    if (!lo_r) m_mode[i] = 0;
                end else begin
                    if (m_want_low[i] == 1) begin
                        if (!lo_r)               m_mode[i] = 0;
                        else if (m_left[i] == 0) m_mode[i] = 2;
                    end else begin
                        if (lo_r)                begin m_want_low[i] = 1; start = 1; end
                        else if (!hi_r)          m_mode[i] = 0;
                        else if (m_left[i] == 0) m_mode[i] = 1;
                    end
                end
                if (start)              m_left[i] = d - 1;
                else if (m_left[i] > 0) m_left[i] = m_left[i] - 1;
                d2_lo[i] = d1_lo[i]; d1_lo[i] = lo_cmd[i];
                d2_hin[i] = d1_hin[i]; d1_hin[i] = hi_cmd_n[i];
            end
            d2_en = d1_en; d1_en = enable_n;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < NP; i++) begin
                bit eh, el;
                eh = (m_mode[i] == 1);
                el = (m_mode[i] == 2);
                vectors++;
                if (hi_gate[i] !== eh || lo_gate[i] !== el) begin
                    fails++;
                    $display("FAIL %s phase %0d at %0t: hi=%b lo=%b expected hi=%b lo=%b",
                             cur_req, i, $time, hi_gate[i], lo_gate[i], eh, el);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        int n;
        int seen;
        // R1: reset and idle
        cur_req = "R1";
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        enable_n = 1'b0;
        wait_cyc(10);

        // R2: exact latency with D=4 -> gate up after edge 7
        cur_req = "R2";
        lo_cmd[0] = 1'b1;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!lo_gate[0] && n < 40);
        vectors++;
        if (n != 7) begin
            fails++;
            $display("FAIL R2 latency: actual %0d edges expected 7", n);
        end
        wait_cyc(5);

        // R3: active-low high request on phase 1
        cur_req = "R3";
        hi_cmd_n[1] = 1'b0;
        wait_cyc(15);

        // R5: both requests on phase 2 -> low wins
        cur_req = "R5";
        lo_cmd[2] = 1'b1; hi_cmd_n[2] = 1'b0;
        wait_cyc(15);

        // R6: preempt conducting high side of phase 1
        cur_req = "R6";
        lo_cmd[1] = 1'b1;
        wait_cyc(15);

        // R7: high request on phase 0 while low conducts, then release low
        cur_req = "R7";
        hi_cmd_n[0] = 1'b0;
        wait_cyc(10);
        lo_cmd[0] = 1'b0;
        wait_cyc(15);

        // R9: disable forces all off; change dead time while off; re-enable
        cur_req = "R9";
        enable_n = 1'b1;
        wait_cyc(6);
        vectors++;
        if (hi_gate !== '0 || lo_gate !== '0) begin
            fails++;
            $display("FAIL R9 disable: actual hi=%b lo=%b expected 000 000", hi_gate, lo_gate);
        end
        dead_cycles = 8'd8;
        wait_cyc(2);
        enable_n = 1'b0;
        wait_cyc(20);

        // R10: withdraw a pending request during the dead interval
        cur_req = "R10";
        lo_cmd = '0; hi_cmd_n = '1;
        wait_cyc(15);
        hi_cmd_n[2] = 1'b0;
        wait_cyc(4);
        hi_cmd_n[2] = 1'b1;
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (hi_gate[2] || lo_gate[2]) seen++;
        end
        vectors++;
        if (seen != 0) begin
            fails++;
            $display("FAIL R10 cancel: actual %0d on-cycles expected 0", seen);
        end

        // R8: zero setting acts as one cycle; rapid handovers on phase 0
        cur_req = "R8";
        enable_n = 1'b1;
        wait_cyc(4);
        dead_cycles = 8'd0;
        wait_cyc(2);
        enable_n = 1'b0;
        wait_cyc(4);
        for (int k = 0; k < 30; k++) begin
            lo_cmd[0] = k[1];
            hi_cmd_n[0] = k[2];
            wait_cyc(1 + (k % 3));
        end
        wait_cyc(10);

        // R11: independent pseudo-random traffic on all phases, D=3
        cur_req = "R11";
        enable_n = 1'b1;
        wait_cyc(4);
        dead_cycles = 8'd3;
        wait_cyc(2);
        enable_n = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) begin
                if ($urandom % 7 == 0) lo_cmd[i] = ~lo_cmd[i];
                if ($urandom % 5 == 0) hi_cmd_n[i] = ~hi_cmd_n[i];
            end
            if ($urandom % 300 == 0) enable_n = ~enable_n;
        end
        wait_cyc(10);

        done = 1'b1;
        report();
        $finish;
    end

endmodule